// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eight peripheral interrupt request lines and presents one interrupt line to a processor. A rising edge on a request line records that request as pending. Among the pending requests that are not masked, the lowest-numbered line wins. When the processor acknowledges, the block returns an 8-bit vector that names the winner. It also moves the winner from the pending set into the in-service set. While a handler is in service, only a line of strictly higher priority can raise the interrupt again. Requests of equal or lower priority wait until an end-of-interrupt command retires the handler.

A small write port loads the vector base and the mask. A single-cycle end-of-interrupt pulse retires the highest-priority handler in service. Two instances can be chained to give fifteen sources. The slave's interrupt output drives master line 2. The master is built with its cascade parameter set, and its cascade-select output becomes the slave's acknowledge. When the master acknowledges line 2, it leaves the vector to the slave.

Top module: `prio_vec_intc`

## Requirements
- R1: A request line is recorded as pending on a 0-to-1 transition only. A line that stays high after its request has been acknowledged does not record a second request.
- R2: The interrupt output is registered. It goes high two clock edges after the edge that first samples an eligible request high.
- R3: Among eligible pending requests, the lowest line index wins. Line 0 has the highest priority.
- R4: The vector is the base register with its low 3 bits replaced by the winning index. It appears on the vector output with the valid flag high for one cycle after the clock edge that samples the acknowledge. The interrupt output is low in that same cycle.
- R5: An acknowledge clears the winner's pending bit and sets its in-service bit.
- R6: While a line is in service, a pending request on a line of lower index raises the interrupt output. A request on the same line or a higher-index line does not.
- R7: An end-of-interrupt pulse clears only the lowest-index in-service bit.
- R8: A set mask bit keeps its line out of arbitration, but the request stays pending. After the mask bit is cleared, the interrupt output rises two edges after the write.
- R9: A configuration write with select 0 loads the vector base. A write with select 1 loads the mask, where bit n masks line n.
- R10: With cascading enabled, acknowledging line 2 drives the cascade-select output high for one cycle and leaves the vector valid flag low. A slave whose acknowledge is driven by that output places its own vector one cycle later.
- R11: An acknowledge while no request is eligible produces no valid vector and changes no state.
- R12: After reset, the interrupt output, vector valid flag and cascade-select output are low. The pending, in-service and mask sets are empty, and the base is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines, index 0 highest priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects vector base, 1 selects mask |
| cfg_data | input | 8 | Configuration write data |
| eoi | input | 1 | End-of-interrupt pulse |
| int_ack | input | 1 | Interrupt acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt line to the processor |
| vec_out | output | 8 | Vector of the acknowledged source |
| vec_valid | output | 1 | Vector output is valid this cycle |
| casc_sel | output | 1 | Tells the cascaded slave to drive its vector |

## Verification
The bench drives inputs on falling edges and samples on falling edges, so every expected value is tied to a known count of rising edges. The interrupt output is due on the second edge after a request edge, and a vector or cascade select is due on the first edge after an acknowledge. An end-of-interrupt or mask write changes the interrupt output on the second edge after the command. Through a cascade, the master interrupt follows a slave request after four edges, and the slave vector follows the master acknowledge after two. Each check samples in exactly that cycle and also one cycle earlier where a premature change would be a fault.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // configuration register select
  typedef enum logic {
    CFG_BASE = 1'b0,
    CFG_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/intc_prio_enc.sv
// Finds the lowest set index of a request vector.
module intc_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_in,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_req_capture.sv
// Rising-edge capture of request lines into a pending set.
module intc_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  logic [N-1:0] line_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise;
    assign rise = irq_in[g] & ~line_q[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[g] <= 1'b0;
        pend[g]   <= 1'b0;
      end else begin
        line_q[g] <= irq_in[g];
        pend[g]   <= (pend[g] & ~clr_vec[g]) | rise;
      end
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((~pend & $past(pend) & ~$past(clr_vec)) == '0));

  // R1
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(irq_in)) == '0));
endmodule

// File: rtl/intc_isr_track.sv
// In-service set with end-of-interrupt retirement of the top entry.
module intc_isr_track #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set_vec,
  input  logic          eoi,
  output logic          top_found,
  output logic [IW-1:0] top_idx
);
  logic [N-1:0] isr;
  logic [N-1:0] retire;

  intc_prio_enc #(.N(N), .IW(IW)) u_top (
    .vec_in (isr),
    .found  (top_found),
    .idx    (top_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_ret
    assign retire[g] = eoi && top_found && (top_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~retire) | set_vec;
  end

  // R7
  eoi_single_chk: assert property (@(posedge clk) disable iff (rst)
    eoi |=> ($countones($past(isr) & ~isr) <= 1));

  // R5
  isr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !eoi |=> ((~isr & $past(isr)) == '0));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int N_IRQ    = 8,
  parameter int VEC_W    = 8,
  parameter bit CASC_EN  = 1'b0,
  parameter int CASC_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [VEC_W-1:0] cfg_data,
  input  logic             eoi,
  input  logic             int_ack,
  output logic             int_out,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid,
  output logic             casc_sel
);
  import intc_pkg::*;

  localparam int IW = $clog2(N_IRQ);

  logic [VEC_W-1:0] base_r;
  logic [N_IRQ-1:0] mask_r;
  logic [N_IRQ-1:0] pend;
  logic [N_IRQ-1:0] cand;
  logic [N_IRQ-1:0] ack_onehot;
  logic             win_found;
  logic [IW-1:0]    win_idx;
  logic             svc_found;
  logic [IW-1:0]    svc_idx;
  logic             eligible;
  logic             take;
  logic             to_slave;

  intc_req_capture #(.N(N_IRQ)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .clr_vec (ack_onehot),
    .pend    (pend)
  );

  assign cand = pend & ~mask_r;

  intc_prio_enc #(.N(N_IRQ), .IW(IW)) u_win (
    .vec_in (cand),
    .found  (win_found),
    .idx    (win_idx)
  );

  intc_isr_track #(.N(N_IRQ), .IW(IW)) u_isr (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (ack_onehot),
    .eoi       (eoi),
    .top_found (svc_found),
    .top_idx   (svc_idx)
  );

  // a request may preempt only a strictly higher-index handler
  assign eligible = win_found && (!svc_found || (win_idx < svc_idx));
  assign take     = int_ack && eligible;
  assign to_slave = CASC_EN && (win_idx == IW'(CASC_IDX));

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ack
    assign ack_onehot[g] = take && (win_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_r <= '0;
      mask_r <= '0;
    end else if (cfg_we) begin
      if (cfg_sel_e'(cfg_sel) == CFG_BASE) base_r <= cfg_data;
      else                                 mask_r <= cfg_data[N_IRQ-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      casc_sel  <= 1'b0;
    end else begin
      int_out   <= eligible && !int_ack;
      vec_valid <= take && !to_slave;
      casc_sel  <= take && to_slave;
      if (take && !to_slave) vec_out <= {base_r[VEC_W-1:IW], win_idx};
    end
  end

  // R4
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(int_ack));

  // R10
  casc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && casc_sel));

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_onehot));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !eligible) |=> (!vec_valid && !casc_sel));
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_m = '0, irq_s = '0;
  logic       cfg_we = 0, cfg_sel = 0, cfg_we_s = 0, cfg_sel_s = 0;
  logic [7:0] cfg_data = '0, cfg_data_s = '0;
  logic       eoi_m = 0, eoi_s = 0, ack_m = 0;
  logic       int_m, vv_m, cs_m, int_s, vv_s, cs_s;
  logic [7:0] vec_m, vec_s;
  logic [7:0] irq_to_m;
  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  assign irq_to_m = {irq_m[7:3], int_s, irq_m[1:0]};

  prio_vec_intc #(.CASC_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_to_m), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .eoi(eoi_m), .int_ack(ack_m), .int_out(int_m),
    .vec_out(vec_m), .vec_valid(vv_m), .casc_sel(cs_m)
  );

  prio_vec_intc #(.CASC_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .irq_in(irq_s), .cfg_we(cfg_we_s), .cfg_sel(cfg_sel_s),
    .cfg_data(cfg_data_s), .eoi(eoi_s), .int_ack(cs_m), .int_out(int_s),
    .vec_out(vec_s), .vec_valid(vv_s), .casc_sel(cs_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_m(input logic sel, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_data = d; cyc(1); cfg_we = 0;
  endtask

  task automatic ack_pulse();
    ack_m = 1; cyc(1); ack_m = 0;
  endtask

  task automatic eoi_pulse();
    eoi_m = 1; cyc(1); eoi_m = 0;
  endtask

  task automatic t_reset();
    chk("R12 int", int_m, 0);
    chk("R12 vv", vv_m, 0);
    chk("R12 cs", cs_m, 0);
    ack_pulse();
    chk("R12 empty pending", vv_m, 0);
  endtask

  task automatic t_single();
    wr_m(1'b0, 8'h20); // R9 base
    irq_m[5] = 1; cyc(1);
    chk("R2 early", int_m, 0);
    cyc(1);
    chk("R2 int", int_m, 1);
    ack_pulse();
    chk("R4 vv", vv_m, 1);
    chk("R4 R9 vec", vec_m, 8'h25);
    chk("R4 int low", int_m, 0);
    chk("R10 no cs", cs_m, 0);
    cyc(3);
    chk("R1 R5 level held", int_m, 0);
    eoi_pulse(); cyc(2);
    chk("R1 no re-record", int_m, 0);
    irq_m[5] = 0; cyc(1);
  endtask

  task automatic t_prio();
    irq_m[6] = 1; irq_m[3] = 1; cyc(2);
    chk("R3 int", int_m, 1);
    ack_pulse();
    chk("R3 vec", vec_m, 8'h23);
    cyc(2);
    chk("R6 lower blocked", int_m, 0);
    eoi_pulse(); cyc(1);
    chk("R7 after eoi", int_m, 1);
    ack_pulse();
    chk("R3 second vec", vec_m, 8'h26);
    eoi_pulse();
    irq_m[6] = 0; irq_m[3] = 0; cyc(1);
  endtask

  task automatic t_nest();
    irq_m[4] = 1; cyc(2);
    ack_pulse();
    chk("R5 vec4", vec_m, 8'h24);
    irq_m[4] = 0; cyc(1);
    irq_m[4] = 1; cyc(3);
    chk("R6 equal blocked", int_m, 0);
    irq_m[1] = 1; cyc(2);
    chk("R6 preempt", int_m, 1);
    ack_pulse();
    chk("R6 vec1", vec_m, 8'h21);
    eoi_pulse(); cyc(2);
    chk("R7 only top cleared", int_m, 0);
    eoi_pulse(); cyc(1);
    chk("R7 second eoi", int_m, 1);
    ack_pulse();
    chk("R7 vec4 again", vec_m, 8'h24);
    eoi_pulse();
    irq_m[4] = 0; irq_m[1] = 0; cyc(1);
  endtask

  task automatic t_mask();
    wr_m(1'b1, 8'h80);
    irq_m[7] = 1; cyc(4);
    chk("R8 masked", int_m, 0);
    wr_m(1'b1, 8'h00);
    chk("R8 unmask early", int_m, 0);
    cyc(1);
    chk("R8 still pending", int_m, 1);
    ack_pulse();
    chk("R8 vec7", vec_m, 8'h27);
    eoi_pulse();
    irq_m[7] = 0; cyc(1);
  endtask

  task automatic t_spurious();
    ack_pulse();
    chk("R11 no vv", vv_m, 0);
    chk("R11 no cs", cs_m, 0);
    irq_m[0] = 1; cyc(2);
    chk("R11 int", int_m, 1);
    ack_pulse();
    chk("R11 vec0", vec_m, 8'h20);
    eoi_pulse();
    irq_m[0] = 0; cyc(1);
  endtask

  task automatic t_cascade();
    cfg_we_s = 1; cfg_sel_s = 0; cfg_data_s = 8'h40; cyc(1); cfg_we_s = 0;
    irq_s[5] = 1; cyc(3);
    chk("R10 master early", int_m, 0);
    cyc(1);
    chk("R10 master int", int_m, 1);
    ack_pulse();
    chk("R10 cs", cs_m, 1);
    chk("R10 master vv low", vv_m, 0);
    cyc(1);
    chk("R10 slave vv", vv_s, 1);
    chk("R10 slave vec", vec_s, 8'h45);
    chk("R10 cs one cycle", cs_m, 0);
    eoi_m = 1; eoi_s = 1; cyc(1); eoi_m = 0; eoi_s = 0;
    irq_s[5] = 0; cyc(2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_single();
    t_prio();
    t_nest();
    t_mask();
    t_spurious();
    t_cascade();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule